// File: doc/BRIEF.md
# Cascaded Card UID Search and Select Controller

This controller runs the reader side of the bitwise identifier search that proximity cards use. After a start request it asks the transmitter for a search frame at the first cascade level. The frame carries a select code, a bit-count byte and the UID bits found so far. When the receiver reports a collision, the controller turns the reported collision position into the count of bits that are now trusted. It merges those bits into its working copy of the level's 40-bit UID field. It then asks for a narrower search frame that carries the collision position as the new bit-count byte.

Once a reply arrives with no collision, the controller checks the level's check byte. It then sends a select frame with the whole field and inspects the acknowledge byte. If that byte says the UID continues, the search starts over at the next cascade level. The identifier bytes of all levels are gathered into one output word, and a one-cycle done pulse marks it as ready. Radio framing and CRC belong to the transmitter and receiver.

The bit-count byte and the collision position share one code: the upper nibble counts whole bytes and the lower nibble counts extra bits. This count includes the two header bytes of the frame. A 40-bit UID field is numbered so that bit 8*b+i is bit i of field byte b. Byte 0 goes out first, and byte 4 is the check byte.

Top module: `casc_select_ctrl`

## Requirements
- R1: A start pulse while idle leads, on the next cycle, to a search frame request with select code 0x93, bit-count byte 0x20 and an all-zero UID field.
- R2: A collision reply with position byte H:L (H upper nibble, L lower nibble) stands for (H-2)*8+L trusted bits. The next search frame carries the position byte itself as its bit-count byte, and all UID bits at or above the trusted count are zero.
- R3: In a merged field, the bits below the previously trusted count keep their earlier values, whatever the receiver returns there. The bits from that count up to the new count come from the receiver.
- R4: Failure code 3 ends the search if a search reply carries the receive error flag, if a collision position has H<2, L>7, a trusted count of 40 or more, or a count not above the current one, or if a select reply reports an error or a collision.
- R5: A search reply without collision whose five field bytes XOR to zero leads to a select frame with bit-count byte 0x70 and the complete 40-bit field.
- R6: Cascade levels 1, 2 and 3 use select codes 0x93, 0x95 and 0x97 in both search and select frames.
- R7: An acknowledge byte with bit 2 set, below the last level, starts the next level with bit-count byte 0x20 and an all-zero field.
- R8: An acknowledge byte with bit 2 set at the last level ends the search with failure code 2.
- R9: A search reply without collision that fails the XOR check restarts the level once from bit-count byte 0x20 with a zeroed field. A second such failure on the same level ends the search with failure code 1.
- R10: On success, done pulses for one cycle, never together with fail. A level that continues contributes field bytes 1 to 3, and the final level contributes bytes 0 to 3. These are packed from the low byte of the UID output upward, so the length reads 4, 7 or 10 bytes.
- R11: A frame request, with its select code, bit-count byte and field, stays unchanged until the transmitter acknowledges it.
- R12: Start has no effect while busy. Right after reset the block is idle with no request, done or fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search at cascade level 1 (idle only) |
| busy | output | 1 | Search in progress |
| tx_req | output | 1 | Frame request to the transmitter |
| tx_ack | input | 1 | Transmitter accepted the frame |
| tx_cmd | output | 8 | Select code of the frame |
| tx_nvb | output | 8 | Bit-count byte of the frame |
| tx_bits | output | 40 | UID field carried by the frame |
| rx_done | input | 1 | Receiver finished a reply |
| rx_err | input | 1 | Reply had a framing or CRC error |
| rx_coll | input | 1 | Reply had a bit collision |
| rx_coll_pos | input | 8 | Collision position, byte/bit nibble code |
| rx_data | input | 40 | Reply field aligned to UID positions; acknowledge byte in bits 7:0 |
| done | output | 1 | One-cycle pulse, UID complete |
| fail | output | 1 | One-cycle pulse, search aborted |
| fail_code | output | 2 | 1 check byte, 2 cascade overrun, 3 link error |
| uid_out | output | 80 | Gathered UID, first byte in bits 7:0 |
| uid_len | output | 4 | Number of valid UID bytes |

## Verification
The assertions take for granted that the transmitter raises tx_ack only while a request is pending. They also assume that rx_done comes only while a reply is awaited, as a single-cycle pulse, with rx_coll_pos meaningful only together with rx_coll. The bench acknowledges each request only after checking it, and drives each reply as a one-cycle pulse in the waiting state. It sets the collision position only on collision replies. Stray start pulses are given only during a wait, which is the case R12 is about.

// File: rtl/casc_sel_pkg.sv
// Shared constants, state and failure types, and helpers for the cascaded
// UID search controller. Assumes a fixed field of four UID bytes plus one
// check byte per cascade level.
package casc_sel_pkg;

    localparam int UID_BYTES   = 4;
    localparam int FIELD_BYTES = UID_BYTES + 1;
    localparam int FIELD_BITS  = FIELD_BYTES * 8;
    localparam int CNT_W       = $clog2(FIELD_BITS + 1);
    localparam int HDR_BYTES   = 2;
    localparam int CASC_BIT    = 2;

    localparam logic [7:0] NVB_EMPTY = 8'h20;
    localparam logic [7:0] NVB_FULL  = 8'h70;
    localparam logic [7:0] SEL_BASE  = 8'h93;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AC_TX,
        ST_AC_RX,
        ST_SEL_TX,
        ST_SEL_RX
    } ctrl_state_t;

    typedef enum logic [1:0] {
        FC_NONE    = 2'd0,
        FC_BCC     = 2'd1,
        FC_CASCADE = 2'd2,
        FC_LINK    = 2'd3
    } fail_code_t;

    // Mask with the lowest n bits of a UID field set.
    function automatic logic [FIELD_BITS-1:0] low_mask(input logic [CNT_W-1:0] n);
        logic [FIELD_BITS-1:0] m;
        for (int i = 0; i < FIELD_BITS; i++) begin
            m[i] = (i < int'(n));
        end
        return m;
    endfunction

    // XOR of all bytes of a field; zero when the check byte agrees.
    function automatic logic [7:0] field_xor(input logic [FIELD_BITS-1:0] f);
        logic [7:0] x;
        x = '0;
        for (int b = 0; b < FIELD_BYTES; b++) begin
            x = x ^ f[b*8 +: 8];
        end
        return x;
    endfunction

endpackage

// File: rtl/casc_pos_decode.sv
// Turns a collision position in byte/bit nibble code into a count of
// trusted UID bits and judges whether it is usable. Assumes the position
// counts the two header bytes of the search frame. Purely combinational.
module casc_pos_decode
    import casc_sel_pkg::*;
(
    input  logic [7:0]       pos,
    input  logic [CNT_W-1:0] cur_bits,
    output logic [CNT_W-1:0] new_bits,
    output logic             pos_ok
);

    logic [7:0] raw_bits;

    always_comb begin : p_decode // strip the header and judge the result
        raw_bits = 8'((int'(pos[7:4]) - HDR_BYTES) * 8 + int'(pos[3:0]));
        pos_ok   = (int'(pos[7:4]) >= HDR_BYTES) && (pos[3:0] < 4'd8)
                   && (int'(raw_bits) < FIELD_BITS)
                   && (raw_bits > 8'(cur_bits));
        new_bits = CNT_W'(raw_bits);
    end

endmodule

// File: rtl/casc_uid_merge.sv
// Combines the trusted part of the working UID field with freshly received
// bits, then clears everything at or above the new trusted count. Assumes the
// receiver aligns reply bits to their absolute field positions.
module casc_uid_merge
    import casc_sel_pkg::*;
(
    input  logic [FIELD_BITS-1:0] known,
    input  logic [CNT_W-1:0]      known_bits,
    input  logic [FIELD_BITS-1:0] rx_field,
    input  logic [CNT_W-1:0]      keep_bits,
    output logic [FIELD_BITS-1:0] merged,
    output logic                  check_ok
);

    logic [FIELD_BITS-1:0] old_mask;
    logic [FIELD_BITS-1:0] new_mask;

    always_comb begin : p_merge // old bits win below the old count, cut at the new
        old_mask = low_mask(known_bits);
        new_mask = low_mask(keep_bits);
        merged   = ((known & old_mask) | (rx_field & ~old_mask)) & new_mask;
        check_ok = (field_xor(merged) == 8'h00);
    end

endmodule

// File: rtl/casc_uid_collect.sv
// Gathers UID bytes across cascade levels. A continued level gives up its
// first byte (the cascade marker) and adds the next three; the final level
// adds all four. Assumes at most MAX_LEVELS pushes between clears.
module casc_uid_collect
    import casc_sel_pkg::*;
#(
    parameter int MAX_LEVELS = 3,
    localparam int OUT_BYTES = (UID_BYTES - 1) * (MAX_LEVELS - 1) + UID_BYTES,
    localparam int LEN_W     = $clog2(OUT_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   push,
    input  logic                   last,
    input  logic [FIELD_BITS-1:0]  field,
    output logic [OUT_BYTES*8-1:0] uid,
    output logic [LEN_W-1:0]       len
);

    logic [OUT_BYTES*8-1:0] uid_nx;
    logic [LEN_W-1:0]       len_nx;

    always_comb begin : p_place // put this level's bytes after the gathered ones
        uid_nx = uid;
        len_nx = len;
        if (push) begin
            for (int j = 0; j < OUT_BYTES; j++) begin
                for (int k = 0; k < UID_BYTES; k++) begin
                    if ((int'(len) + k == j) && (last || k < UID_BYTES - 1)) begin
                        uid_nx[j*8 +: 8] = field[(last ? k : k + 1)*8 +: 8];
                    end
                end
            end
            len_nx = len + LEN_W'(last ? UID_BYTES : UID_BYTES - 1);
        end
    end

    always_ff @(posedge clk) begin : p_store // hold the gathered identifier
        if (!rst_n || clear) begin
            uid <= '0;
            len <= '0;
        end else begin
            uid <= uid_nx;
            len <= len_nx;
        end
    end

    p_len_bound_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (int'(len) <= OUT_BYTES));

endmodule

// File: rtl/casc_select_ctrl.sv
// Reader-side cascaded UID search and select sequencer. Issues search frames
// with a growing bit-count byte, narrows them on each collision, checks the
// check byte, selects, and walks cascade levels as the acknowledge byte asks.
// Assumes tx_ack only while tx_req is high, and rx_done as a one-cycle pulse
// while a reply is awaited.
module casc_select_ctrl
    import casc_sel_pkg::*;
#(
    parameter int MAX_LEVELS = 3,
    localparam int OUT_BYTES = (UID_BYTES - 1) * (MAX_LEVELS - 1) + UID_BYTES,
    localparam int LEN_W     = $clog2(OUT_BYTES + 1),
    localparam int LVL_W     = (MAX_LEVELS > 1) ? $clog2(MAX_LEVELS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    output logic                   busy,
    output logic                   tx_req,
    input  logic                   tx_ack,
    output logic [7:0]             tx_cmd,
    output logic [7:0]             tx_nvb,
    output logic [FIELD_BITS-1:0]  tx_bits,
    input  logic                   rx_done,
    input  logic                   rx_err,
    input  logic                   rx_coll,
    input  logic [7:0]             rx_coll_pos,
    input  logic [FIELD_BITS-1:0]  rx_data,
    output logic                   done,
    output logic                   fail,
    output logic [1:0]             fail_code,
    output logic [OUT_BYTES*8-1:0] uid_out,
    output logic [LEN_W-1:0]       uid_len
);

    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(MAX_LEVELS - 1);

    ctrl_state_t           state;
    logic [LVL_W-1:0]      level;
    logic [FIELD_BITS-1:0] known;
    logic [CNT_W-1:0]      known_bits;
    logic [7:0]            nvb;
    logic                  retried;
    fail_code_t            fcode;

    logic [CNT_W-1:0]      pos_bits;
    logic                  pos_ok;
    logic [CNT_W-1:0]      keep_bits;
    logic [FIELD_BITS-1:0] merged;
    logic                  check_ok;
    logic                  sak_more;
    logic                  col_clear;
    logic                  col_push;

    casc_pos_decode i_pos (
        .pos      (rx_coll_pos),
        .cur_bits (known_bits),
        .new_bits (pos_bits),
        .pos_ok   (pos_ok)
    );

    always_comb begin : p_keep // a collision cuts the field, a clean reply keeps all
        keep_bits = rx_coll ? pos_bits : CNT_W'(FIELD_BITS);
    end

    casc_uid_merge i_merge (
        .known      (known),
        .known_bits (known_bits),
        .rx_field   (rx_data),
        .keep_bits  (keep_bits),
        .merged     (merged),
        .check_ok   (check_ok)
    );

    always_comb begin : p_collect_ctl // decide when gathered bytes change
        sak_more  = rx_data[CASC_BIT];
        col_clear = (state == ST_IDLE) && start;
        col_push  = (state == ST_SEL_RX) && rx_done && !rx_err && !rx_coll
                    && !(sak_more && level == LAST_LVL);
    end

    casc_uid_collect #(.MAX_LEVELS(MAX_LEVELS)) i_collect (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (col_clear),
        .push  (col_push),
        .last  (!sak_more),
        .field (known),
        .uid   (uid_out),
        .len   (uid_len)
    );

    always_comb begin : p_tx // present the pending frame to the transmitter
        busy    = (state != ST_IDLE);
        tx_req  = (state == ST_AC_TX) || (state == ST_SEL_TX);
        tx_cmd  = SEL_BASE + 8'({level, 1'b0});
        tx_nvb  = (state == ST_SEL_TX) ? NVB_FULL : nvb;
        tx_bits = known;
        fail_code = fcode;
    end

    always_ff @(posedge clk) begin : p_seq // step through search, select and levels
        if (!rst_n) begin
            state      <= ST_IDLE;
            level      <= '0;
            known      <= '0;
            known_bits <= '0;
            nvb        <= NVB_EMPTY;
            retried    <= 1'b0;
            done       <= 1'b0;
            fail       <= 1'b0;
            fcode      <= FC_NONE;
        end else begin
            done <= 1'b0;
            fail <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        level      <= '0;
                        known      <= '0;
                        known_bits <= '0;
                        nvb        <= NVB_EMPTY;
                        retried    <= 1'b0;
                        fcode      <= FC_NONE;
                        state      <= ST_AC_TX;
                    end
                end
                ST_AC_TX: begin
                    if (tx_ack) state <= ST_AC_RX;
                end
                ST_AC_RX: begin
                    if (rx_done) begin
                        if (rx_err || (rx_coll && !pos_ok)) begin
                            fail  <= 1'b1;
                            fcode <= FC_LINK;
                            state <= ST_IDLE;
                        end else if (rx_coll) begin
                            known      <= merged;
                            known_bits <= pos_bits;
                            nvb        <= rx_coll_pos;
                            state      <= ST_AC_TX;
                        end else if (check_ok) begin
                            known      <= merged;
                            known_bits <= CNT_W'(FIELD_BITS);
                            state      <= ST_SEL_TX;
                        end else if (!retried) begin
                            retried    <= 1'b1;
                            known      <= '0;
                            known_bits <= '0;
                            nvb        <= NVB_EMPTY;
                            state      <= ST_AC_TX;
                        end else begin
                            fail  <= 1'b1;
                            fcode <= FC_BCC;
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_SEL_TX: begin
                    if (tx_ack) state <= ST_SEL_RX;
                end
                ST_SEL_RX: begin
                    if (rx_done) begin
                        if (rx_err || rx_coll) begin
                            fail  <= 1'b1;
                            fcode <= FC_LINK;
                            state <= ST_IDLE;
                        end else if (sak_more && level == LAST_LVL) begin
                            fail  <= 1'b1;
                            fcode <= FC_CASCADE;
                            state <= ST_IDLE;
                        end else if (sak_more) begin
                            level      <= level + 1'b1;
                            known      <= '0;
                            known_bits <= '0;
                            nvb        <= NVB_EMPTY;
                            retried    <= 1'b0;
                            state      <= ST_AC_TX;
                        end else begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_first_frame_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (tx_req && tx_nvb == NVB_EMPTY && tx_bits == '0));

    p_coll_nvb_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AC_RX && rx_done && !rx_err && rx_coll && pos_ok)
        |=> (tx_req && tx_nvb == $past(rx_coll_pos)));

    p_sel_check_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_nvb == NVB_FULL) |-> (field_xor(tx_bits) == 8'h00));

    p_sel_code_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> (tx_cmd == 8'h93 || tx_cmd == 8'h95 || tx_cmd == 8'h97));

    p_overrun_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (fail && fail_code == FC_CASCADE) |-> (level == LAST_LVL));

    p_excl_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    p_hold_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_ack) |=> (tx_req && $stable(tx_cmd) && $stable(tx_nvb)
                                 && $stable(tx_bits)));

endmodule

// File: tb/test_casc_select_ctrl.sv
module test_casc_select_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy;
    logic        tx_req;
    logic        tx_ack = 1'b0;
    logic [7:0]  tx_cmd;
    logic [7:0]  tx_nvb;
    logic [39:0] tx_bits;
    logic        rx_done = 1'b0;
    logic        rx_err = 1'b0;
    logic        rx_coll = 1'b0;
    logic [7:0]  rx_coll_pos = 8'h00;
    logic [39:0] rx_data = '0;
    logic        done;
    logic        fail;
    logic [1:0]  fail_code;
    logic [79:0] uid_out;
    logic [3:0]  uid_len;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    casc_select_ctrl i_casc_select_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .tx_req(tx_req), .tx_ack(tx_ack), .tx_cmd(tx_cmd), .tx_nvb(tx_nvb),
        .tx_bits(tx_bits), .rx_done(rx_done), .rx_err(rx_err),
        .rx_coll(rx_coll), .rx_coll_pos(rx_coll_pos), .rx_data(rx_data),
        .done(done), .fail(fail), .fail_code(fail_code),
        .uid_out(uid_out), .uid_len(uid_len)
    );

    function automatic logic [39:0] lm(input int n);
        return (n >= 40) ? {40{1'b1}} : ((40'h1 << n) - 40'h1);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [79:0] act,
                       input logic [79:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Check one frame request, accept it, then answer with one reply.
    task automatic xchg(input string tag, input logic [7:0] ecmd,
                        input logic [7:0] envb, input logic [39:0] ebits,
                        input int hold, input bit poke,
                        input logic coll, input logic [7:0] pos,
                        input logic err, input logic [39:0] data);
        int n = 0;
        while (!tx_req && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(tx_req == 1'b1, {tag, " request"}, 80'(tx_req), 80'h1);
        chk(tx_cmd == ecmd, {tag, " code"}, 80'(tx_cmd), 80'(ecmd));
        chk(tx_nvb == envb, {tag, " count byte"}, 80'(tx_nvb), 80'(envb));
        chk(tx_bits == ebits, {tag, " field"}, 80'(tx_bits), 80'(ebits));
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(tx_req && tx_cmd == ecmd && tx_nvb == envb && tx_bits == ebits,
                {tag, " R11 held request"}, 80'(tx_bits), 80'(ebits));
        end
        tx_ack = 1'b1;
        @(negedge clk);
        tx_ack = 1'b0;
        if (poke) pulse_start();
        rx_done = 1'b1; rx_coll = coll; rx_coll_pos = pos;
        rx_err = err; rx_data = data;
        @(negedge clk);
        rx_done = 1'b0; rx_coll = 1'b0; rx_coll_pos = 8'h00;
        rx_err = 1'b0; rx_data = '0;
    endtask

    task automatic expect_done(input string tag, input logic [3:0] len,
                               input logic [79:0] uid);
        chk(done == 1'b1 && fail == 1'b0, {tag, " done pulse"}, 80'(done), 80'h1);
        chk(uid_len == len, {tag, " length"}, 80'(uid_len), 80'(len));
        chk(uid_out == uid, {tag, " uid"}, uid_out, uid);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, {tag, " single pulse"}, 80'(done), 80'h0);
    endtask

    task automatic expect_fail(input string tag, input logic [1:0] code);
        chk(fail == 1'b1 && done == 1'b0, {tag, " fail pulse"}, 80'(fail), 80'h1);
        chk(fail_code == code, {tag, " fail code"}, 80'(fail_code), 80'(code));
        @(negedge clk);
        chk(busy == 1'b0, {tag, " idle after fail"}, 80'(busy), 80'h0);
    endtask

    task automatic t_reset();
        chk(!busy && !tx_req && !done && !fail, "R12 reset idle",
            {76'h0, busy, tx_req, done, fail}, 80'h0);
        chk(uid_len == 4'd0, "R12 reset length", 80'(uid_len), 80'h0);
    endtask

    task automatic t_single();
        pulse_start();
        xchg("R1 first frame", 8'h93, 8'h20, 40'h0, 3, 1'b0,
             1'b0, 8'h00, 1'b0, 40'h08_78563412);
        xchg("R5 select frame", 8'h93, 8'h70, 40'h08_78563412, 0, 1'b0,
             1'b0, 8'h00, 1'b0, 40'h20);
        expect_done("R10 single", 4'd4, 80'h78563412);
    endtask

    task automatic t_collide();
        logic [39:0] c;
        c = 40'h00_960F3CA5;
        pulse_start();
        xchg("R1 search", 8'h93, 8'h20, 40'h0, 0, 1'b0,
             1'b1, 8'h35, 1'b0, c | ~lm(13));
        xchg("R2 narrowed 13", 8'h93, 8'h35, c & lm(13), 0, 1'b0,
             1'b1, 8'h52, 1'b0, (c ^ lm(13)) | ~lm(26));
        xchg("R3 merged 26", 8'h93, 8'h52, c & lm(26), 0, 1'b0,
             1'b0, 8'h00, 1'b0, c ^ lm(26));
        xchg("R3 full select", 8'h93, 8'h70, c, 0, 1'b0,
             1'b0, 8'h00, 1'b0, 40'h00);
        expect_done("R2 collided", 4'd4, 80'h960F3CA5);
    endtask

    task automatic t_triple(input bit overrun);
        pulse_start();
        xchg("R6 level1 search", 8'h93, 8'h20, 40'h0, 0, 1'b0,
             1'b0, 8'h00, 1'b0, 40'h88_03020188);
        xchg("R6 level1 select", 8'h93, 8'h70, 40'h88_03020188, 0, 1'b0,
             1'b0, 8'h00, 1'b0, 40'h04);
        xchg("R7 level2 search", 8'h95, 8'h20, 40'h0, 0, 1'b0,
             1'b0, 8'h00, 1'b0, 40'h8F_06050488);
        xchg("R6 level2 select", 8'h95, 8'h70, 40'h8F_06050488, 0, 1'b0,
             1'b0, 8'h00, 1'b0, 40'h04);
        xchg("R7 level3 search", 8'h97, 8'h20, 40'h0, 0, 1'b0,
             1'b0, 8'h00, 1'b0, 40'h0C_0A090807);
        xchg("R6 level3 select", 8'h97, 8'h70, 40'h0C_0A090807, 0, 1'b0,
             1'b0, 8'h00, 1'b0, overrun ? 40'h24 : 40'h20);
        if (overrun) expect_fail("R8 cascade overrun", 2'd2);
        else expect_done("R10 triple", 4'd10, 80'h0A090807060504030201);
    endtask

    task automatic t_bcc();
        pulse_start();
        xchg("R9 first try", 8'h93, 8'h20, 40'h0, 0, 1'b0,
             1'b0, 8'h00, 1'b0, 40'hFF_04030201);
        xchg("R9 retry frame", 8'h93, 8'h20, 40'h0, 0, 1'b0,
             1'b0, 8'h00, 1'b0, 40'hFF_04030201);
        expect_fail("R9 second bad check", 2'd1);
    endtask

    task automatic t_link();
        pulse_start();
        xchg("R4 low position", 8'h93, 8'h20, 40'h0, 0, 1'b0,
             1'b1, 8'h18, 1'b0, 40'h0);
        expect_fail("R4 low position", 2'd3);
        pulse_start();
        xchg("R4 receive error", 8'h93, 8'h20, 40'h0, 0, 1'b0,
             1'b0, 8'h00, 1'b1, 40'h0);
        expect_fail("R4 receive error", 2'd3);
        pulse_start();
        xchg("R4 first collision", 8'h93, 8'h20, 40'h0, 0, 1'b0,
             1'b1, 8'h35, 1'b0, 40'hFF);
        xchg("R4 same position", 8'h93, 8'h35, 40'hFF & lm(13), 0, 1'b0,
             1'b1, 8'h35, 1'b0, 40'hFF);
        expect_fail("R4 position not advancing", 2'd3);
    endtask

    task automatic t_busy_start();
        pulse_start();
        xchg("R12 search", 8'h93, 8'h20, 40'h0, 0, 1'b1,
             1'b1, 8'h35, 1'b0, 40'h1FFF);
        xchg("R12 start ignored", 8'h93, 8'h35, 40'h1FFF, 0, 1'b0,
             1'b0, 8'h00, 1'b1, 40'h0);
        expect_fail("R12 run continued", 2'd3);
    endtask

    initial begin : p_watchdog
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin : p_main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_collide();
        t_triple(1'b0);
        t_triple(1'b1);
        t_bcc();
        t_link();
        t_busy_start();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule